// File: doc/BRIEF.md
# Supply Supervisor Sequencer

This block watches a multi-rail power supply through digital comparator flags and decides when the supply may be declared good and when it must be shut down. It receives over-voltage flags for the 3.3 V, 5 V and 12 V rails, under-voltage flags for the 3.3 V and 5 V rails, an external power-good input, and an active-low on/off request. Every rail flag and the power-good input pass a short noise filter. The on/off request passes a much longer debounce filter. A tick prescaler derives both timebases from the system clock.

A central state machine has four states. `ST_OFF` is entered while the request asks for off. `ST_RAMP` is the startup window, in which under-voltage is ignored. `ST_RUN` is normal supervision. `ST_FAULT` is a latched shutdown. Its transitions are:
- OFF→RAMP when the debounced request falls.
- RAMP→RUN when the startup window expires.
- RAMP→FAULT on a filtered over-voltage.
- RUN→FAULT on a filtered over- or under-voltage.
- Any state→OFF when the debounced request rises.

A second machine produces the power-good output. Its states are `PG_IDLE`, `PG_COUNT` and `PG_HELD`. It moves IDLE→COUNT when the good condition appears, COUNT→HELD when the hold count completes, and COUNT/HELD→IDLE as soon as the condition drops. Each noise filter is a two-state machine, `DG_STABLE`/`DG_PENDING`.

Top module: `psu_supervisor`

## Requirements
- R1: After reset `fault_out` is 1 and `pwr_good` is 0.
- R2: The rail flags and `pg_in` are active high. A level change is acted on only after it has persisted for `GLITCH_TICKS` consecutive fine ticks. Fine ticks occur once every `FINE_DIV` clocks. A shorter pulse has no effect on either output.
- R3: `on_req_n` is low for on and high for off. A change is acted on only after it has persisted for `ONOFF_TICKS` coarse ticks. Coarse ticks occur once every `COARSE_DIV` fine ticks and coincide with a fine tick. A shorter pulse has no effect.
- R4: A filtered over-voltage on any of the three rails, in RAMP or RUN, sets `fault_out` to 1 and `pwr_good` to 0.
- R5: Once set by a fault, `fault_out` stays 1 after the flag clears. It is released only by an off request followed by a new on request.
- R6: While the debounced request is off, `fault_out` is 1 and `pwr_good` is 0.
- R7: Under-voltage flags are ignored for `UV_HOLD_TICKS` coarse ticks after the debounced request falls. After that window they trip the fault exactly as over-voltage does.
- R8: `pwr_good` rises only after `pg_in` is high and both under-voltage flags are low continuously for `PG_HOLD_TICKS` coarse ticks, with no fault and the supply on. Any break restarts the count.
- R9: `pwr_good` falls one clock after the good condition drops. A low `pg_in` alone is not a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ov33_flag | input | 1 | 3.3 V over-voltage comparator flag |
| ov5_flag | input | 1 | 5 V over-voltage comparator flag |
| ov12_flag | input | 1 | 12 V over-voltage comparator flag |
| uv33_flag | input | 1 | 3.3 V under-voltage comparator flag |
| uv5_flag | input | 1 | 5 V under-voltage comparator flag |
| pg_in | input | 1 | External power-good input |
| on_req_n | input | 1 | On/off request, low = on |
| pwr_good | output | 1 | Power-good output |
| fault_out | output | 1 | Latched fault / shutdown output, high = shut down |

## Verification
A rail flag reaches `fault_out` after the following stages:
- two synchronizer clocks;
- `GLITCH_TICKS` fine ticks, whose phase is unknown, so the wait is up to one extra tick;
- one state register;
- one output register.

An on/off change adds the same synchronizer and register stages, but spends `ONOFF_TICKS` coarse ticks in its filter. The startup window and the power-good hold each add their coarse count on top of that debounce.

The bench is run with small tick counts. For every check it computes the earliest and latest cycle at which the output can change. It queues each expectation only where both bounds agree: after the latest possible change, or before the earliest possible one. The monitor compares each expectation just after the following rising edge.

// File: rtl/psu_pkg.sv
package psu_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RAMP  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } sup_state_e;

    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_COUNT = 2'd1,
        PG_HELD  = 2'd2
    } pg_state_e;

    typedef enum logic {
        DG_STABLE  = 1'b0,
        DG_PENDING = 1'b1
    } dg_state_e;

    localparam int unsigned NUM_FLAGS = 6;
    localparam int unsigned FLG_OV33  = 0;
    localparam int unsigned FLG_OV5   = 1;
    localparam int unsigned FLG_OV12  = 2;
    localparam int unsigned FLG_UV33  = 3;
    localparam int unsigned FLG_UV5   = 4;
    localparam int unsigned FLG_PGIN  = 5;

endpackage

// File: rtl/psu_tick_gen.sv
module psu_tick_gen #(
    parameter int unsigned FINE_DIV   = 50,
    parameter int unsigned COARSE_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic fine_tick,
    output logic coarse_tick
);
    localparam int unsigned FW = (FINE_DIV > 1) ? $clog2(FINE_DIV) : 1;
    localparam int unsigned CW = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;
    localparam logic [FW-1:0] F_LAST = FW'(FINE_DIV - 1);
    localparam logic [CW-1:0] C_LAST = CW'(COARSE_DIV - 1);

    logic [FW-1:0] fcnt_q;
    logic [CW-1:0] ccnt_q;

    assign fine_tick   = (fcnt_q == F_LAST);
    assign coarse_tick = fine_tick && (ccnt_q == C_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q <= '0;
        end else if (fine_tick) begin
            fcnt_q <= '0;
        end else begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccnt_q <= '0;
        end else if (coarse_tick) begin
            ccnt_q <= '0;
        end else if (fine_tick) begin
            ccnt_q <= ccnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/psu_deglitch.sv
module psu_deglitch #(
    parameter int unsigned HOLD_TICKS = 73,
    parameter logic        RESET_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic clean
);
    import psu_pkg::*;

    localparam int unsigned CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [1:0]    sync_q;
    dg_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          clean_q, clean_d;
    logic          differs;

    // two-flop synchronizer for the asynchronous comparator level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RESET_VAL}};
        end else begin
            sync_q <= {sync_q[0], raw};
        end
    end

    assign differs = sync_q[1] ^ clean_q;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        clean_d = clean_q;
        unique case (st_q)
            DG_STABLE: begin
                if (differs) begin
                    st_d  = DG_PENDING;
                    cnt_d = '0;
                end
            end
            DG_PENDING: begin
                if (!differs) begin
                    st_d = DG_STABLE;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        clean_d = ~clean_q;
                        st_d    = DG_STABLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: st_d = DG_STABLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DG_STABLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_q <= RESET_VAL;
        end else begin
            cnt_q   <= cnt_d;
            clean_q <= clean_d;
        end
    end

    assign clean = clean_q;

endmodule

// File: rtl/psu_pg_seq.sv
module psu_pg_seq #(
    parameter int unsigned HOLD_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic good,
    output logic pg
);
    import psu_pkg::*;

    localparam int unsigned CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    pg_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pg_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PG_IDLE: begin
                if (good) begin
                    st_d  = PG_COUNT;
                    cnt_d = '0;
                end
            end
            PG_COUNT: begin
                if (!good) begin
                    st_d = PG_IDLE;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        st_d = PG_HELD;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PG_HELD: begin
                if (!good) begin
                    st_d = PG_IDLE;
                end
            end
            default: st_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PG_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output register, decoded from the next state so a drop costs one clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= 1'b0;
        end else begin
            pg_q <= (st_d == PG_HELD);
        end
    end

    assign pg = pg_q;

endmodule

// File: rtl/psu_supervisor.sv
module psu_supervisor #(
    parameter int unsigned FINE_DIV      = 50,
    parameter int unsigned COARSE_DIV    = 1000,
    parameter int unsigned GLITCH_TICKS  = 73,
    parameter int unsigned ONOFF_TICKS   = 38,
    parameter int unsigned UV_HOLD_TICKS = 75,
    parameter int unsigned PG_HOLD_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov33_flag,
    input  logic ov5_flag,
    input  logic ov12_flag,
    input  logic uv33_flag,
    input  logic uv5_flag,
    input  logic pg_in,
    input  logic on_req_n,
    output logic pwr_good,
    output logic fault_out
);
    import psu_pkg::*;

    localparam int unsigned UW = (UV_HOLD_TICKS > 1) ? $clog2(UV_HOLD_TICKS) : 1;
    localparam logic [UW-1:0] UV_LAST = UW'(UV_HOLD_TICKS - 1);

    logic                 fine_tick;
    logic                 coarse_tick;
    logic [NUM_FLAGS-1:0] raw_vec;
    logic [NUM_FLAGS-1:0] clean_vec;
    logic                 off_db;
    logic                 ov_any;
    logic                 uv_any;
    logic                 good_cond;
    sup_state_e           state_q, state_d;
    logic [UW-1:0]        uv_cnt_q;
    logic                 fault_q;

    psu_tick_gen #(
        .FINE_DIV   (FINE_DIV),
        .COARSE_DIV (COARSE_DIV)
    ) u_ticks (
        .clk         (clk),
        .rst_n       (rst_n),
        .fine_tick   (fine_tick),
        .coarse_tick (coarse_tick)
    );

    always_comb begin
        raw_vec            = '0;
        raw_vec[FLG_OV33]  = ov33_flag;
        raw_vec[FLG_OV5]   = ov5_flag;
        raw_vec[FLG_OV12]  = ov12_flag;
        raw_vec[FLG_UV33]  = uv33_flag;
        raw_vec[FLG_UV5]   = uv5_flag;
        raw_vec[FLG_PGIN]  = pg_in;
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag_filter
        psu_deglitch #(
            .HOLD_TICKS (GLITCH_TICKS),
            .RESET_VAL  (1'b0)
        ) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (fine_tick),
            .raw   (raw_vec[gi]),
            .clean (clean_vec[gi])
        );
    end

    psu_deglitch #(
        .HOLD_TICKS (ONOFF_TICKS),
        .RESET_VAL  (1'b1)
    ) u_onoff (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (coarse_tick),
        .raw   (on_req_n),
        .clean (off_db)
    );

    assign ov_any = clean_vec[FLG_OV33] | clean_vec[FLG_OV5] | clean_vec[FLG_OV12];
    assign uv_any = clean_vec[FLG_UV33] | clean_vec[FLG_UV5];

    // supervisor next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!off_db) state_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (off_db) begin
                    state_d = ST_OFF;
                end else if (ov_any) begin
                    state_d = ST_FAULT;
                end else if (coarse_tick && (uv_cnt_q == UV_LAST)) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (off_db) begin
                    state_d = ST_OFF;
                end else if (ov_any || uv_any) begin
                    state_d = ST_FAULT;
                end
            end
            ST_FAULT: begin
                if (off_db) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // startup window counter, held at zero outside the ramp state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_cnt_q <= '0;
        end else if (state_q != ST_RAMP) begin
            uv_cnt_q <= '0;
        end else if (coarse_tick) begin
            uv_cnt_q <= uv_cnt_q + 1'b1;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b1;
        end else begin
            fault_q <= (state_q == ST_OFF) || (state_q == ST_FAULT);
        end
    end

    assign good_cond = ((state_q == ST_RAMP) || (state_q == ST_RUN))
                       && clean_vec[FLG_PGIN]
                       && !clean_vec[FLG_UV33]
                       && !clean_vec[FLG_UV5];

    psu_pg_seq #(
        .HOLD_TICKS (PG_HOLD_TICKS)
    ) u_pg (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (coarse_tick),
        .good  (good_cond),
        .pg    (pwr_good)
    );

    assign fault_out = fault_q;

endmodule

// File: rtl/psu_supervisor_chk.sv
module psu_supervisor_chk #(
    parameter int unsigned FINE_DIV = 50
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fine_tick,
    input logic                 coarse_tick,
    input psu_pkg::sup_state_e  state_q,
    input logic                 off_db,
    input logic                 ov_any,
    input logic                 good_cond,
    input logic                 fault_out,
    input logic                 pwr_good
);
    import psu_pkg::*;

    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (fine_tick) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    a_r1_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fault_out && !pwr_good));

    a_r2_fine_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_tick && seen_q) |-> (gap_q == FINE_DIV - 1));

    a_r3_coarse_on_fine: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_tick |-> fine_tick);

    a_r4_overvoltage_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_any && !off_db && ((state_q == ST_RAMP) || (state_q == ST_RUN)))
        |=> ##1 (fault_out && !pwr_good));

    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FAULT) && !off_db) |=> (state_q == ST_FAULT));

    a_r6_off_forces_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> fault_out);

    a_r7_uv_masked_in_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RAMP) && !ov_any) |=> (state_q != ST_FAULT));

    a_r8_pg_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> $past(good_cond));

    a_r9_pg_drops_fast: assert property (@(posedge clk) disable iff (!rst_n)
        !good_cond |=> !pwr_good);

endmodule

bind psu_supervisor psu_supervisor_chk #(
    .FINE_DIV (FINE_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fine_tick   (fine_tick),
    .coarse_tick (coarse_tick),
    .state_q     (state_q),
    .off_db      (off_db),
    .ov_any      (ov_any),
    .good_cond   (good_cond),
    .fault_out   (fault_out),
    .pwr_good    (pwr_good)
);

// File: tb/psu_supervisor_bench.sv
module psu_supervisor_bench;

    localparam int unsigned T_FINE   = 4;
    localparam int unsigned T_COARSE = 8;

    typedef struct {
        logic  pg;
        logic  flt;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov33 = 1'b0, ov5 = 1'b0, ov12 = 1'b0;
    logic uv33 = 1'b0, uv5 = 1'b0, pgin = 1'b0;
    logic req_n = 1'b1;
    logic pwr_good, fault_out;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;

    psu_supervisor #(
        .FINE_DIV      (T_FINE),
        .COARSE_DIV    (T_COARSE),
        .GLITCH_TICKS  (3),
        .ONOFF_TICKS   (2),
        .UV_HOLD_TICKS (4),
        .PG_HOLD_TICKS (6)
    ) u_psu_supervisor (
        .clk       (clk),
        .rst_n     (rst_n),
        .ov33_flag (ov33),
        .ov5_flag  (ov5),
        .ov12_flag (ov12),
        .uv33_flag (uv33),
        .uv5_flag  (uv5),
        .pg_in     (pgin),
        .on_req_n  (req_n),
        .pwr_good  (pwr_good),
        .fault_out (fault_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic pg, input logic flt, input string tag);
        exp_t e;
        e.pg  = pg;
        e.flt = flt;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: drain expectations just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (pwr_good !== e.pg || fault_out !== e.flt) begin
                    n_fail++;
                    $display("FAIL %s: pwr_good=%0b fault_out=%0b expected pwr_good=%0b fault_out=%0b",
                             e.tag, pwr_good, fault_out, e.pg, e.flt);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(1);
        expect_out(1'b0, 1'b1, "R1 reset state");

        // rails still low, external good present, request still off
        pgin = 1'b1; uv33 = 1'b1; uv5 = 1'b1;
        wait_clk(50);
        expect_out(1'b0, 1'b1, "R6 off holds shutdown");

        // turn on with rails below threshold: startup window masks UV
        req_n = 1'b0;
        wait_clk(80);
        expect_out(1'b0, 1'b0, "R7 UV masked in startup window");
        wait_clk(10);
        uv33 = 1'b0; uv5 = 1'b0;
        wait_clk(30);
        expect_out(1'b0, 1'b0, "R8 pg not yet after hold start");
        wait_clk(290);
        expect_out(1'b1, 1'b0, "R8 pg after continuous good");

        // short glitches on rail flags
        ov5 = 1'b1; wait_clk(6); ov5 = 1'b0;
        wait_clk(40);
        expect_out(1'b1, 1'b0, "R2 OV glitch rejected");
        uv33 = 1'b1; wait_clk(6); uv33 = 1'b0;
        wait_clk(40);
        expect_out(1'b1, 1'b0, "R2 UV glitch rejected");

        // short on/off bounce
        req_n = 1'b1; wait_clk(20); req_n = 1'b0;
        wait_clk(100);
        expect_out(1'b1, 1'b0, "R3 request bounce rejected");

        // real over-voltage on 12 V, then released
        ov12 = 1'b1; wait_clk(40); ov12 = 1'b0;
        wait_clk(40);
        expect_out(1'b0, 1'b1, "R4 12V OV trips fault");
        wait_clk(300);
        expect_out(1'b0, 1'b1, "R5 fault stays latched");

        // off then on clears the latch
        req_n = 1'b1;
        wait_clk(120);
        expect_out(1'b0, 1'b1, "R6 off after fault");
        req_n = 1'b0;
        wait_clk(400);
        expect_out(1'b1, 1'b0, "R5 latch cleared by toggle");

        // under-voltage after the window trips
        uv5 = 1'b1;
        wait_clk(40);
        expect_out(1'b0, 1'b1, "R7 UV trips after window");
        req_n = 1'b1;
        wait_clk(120);
        req_n = 1'b0;
        wait_clk(80);
        expect_out(1'b0, 1'b0, "R7 UV masked after restart");
        wait_clk(250);
        expect_out(1'b0, 1'b1, "R7 UV trips once window ends");

        // pg count restarts when pg_in breaks during the hold
        uv5 = 1'b0;
        req_n = 1'b1;
        wait_clk(120);
        req_n = 1'b0;
        wait_clk(150);
        pgin = 1'b0; wait_clk(30); pgin = 1'b1;
        wait_clk(160);
        expect_out(1'b0, 1'b0, "R8 hold count restarted");
        wait_clk(160);
        expect_out(1'b1, 1'b0, "R8 pg after restarted hold");

        // pg_in loss drops pg quickly, no fault
        pgin = 1'b0;
        wait_clk(30);
        expect_out(1'b0, 1'b0, "R9 pg drop without fault");
        pgin = 1'b1;
        wait_clk(250);
        expect_out(1'b1, 1'b0, "R9 pg returns");

        // over-voltage on 3.3 V early after turn-on
        req_n = 1'b1;
        wait_clk(120);
        req_n = 1'b0;
        wait_clk(80);
        expect_out(1'b0, 1'b0, "R4 ramp before OV");
        ov33 = 1'b1;
        wait_clk(40);
        expect_out(1'b0, 1'b1, "R4 3.3V OV trips fault");
        ov33 = 1'b0;

        wait_clk(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule